// File: doc/BRIEF.md
# Configurable Test Address Generator

This block produces the address stream for a memory traffic generator. It runs in one of three modes. Sequential mode steps from a configured start address by a configured increment. Random mode takes each address from a 25-bit linear feedback shift register. Random-sequential mode draws one random base and then walks a configured number of further addresses from it by the increment. All arithmetic wraps at 25 bits. An optional mask can overlay one address field (column, bank, bank group or row). The overlay either pins the field to a fixed value or sweeps it through every value it can take, one step per request.

The consumer sees the current address on `addr`. A pulse on `req_next` moves the generator to the following address on the next clock edge. Traffic is organised in blocks. A pulse on `block_done` marks a block boundary, and the generator keeps a copy of its whole state as it stands there. A pulse on `restart` returns to that copy, so the read phase of a block can replay exactly the addresses its write phase used, random ones included. With the return-to-start flag set in sequential mode, each block boundary also reloads the start address. Configuration is sampled into the stepping state during reset. The mask settings act on the output combinationally.

The stepping core is a four-state machine, encoded on `phase`:
- LINEAR: sequential mode. A request adds the increment.
- RANDOM: random mode. A request advances the shift register.
- BASE: random-sequential mode, showing a random base. A request moves to RUN, or, with a run length of zero, draws the next base and stays in BASE.
- RUN: random-sequential mode, inside a run. A request adds the increment until the run count reaches the run length. It then draws the next base and moves to BASE.

Reset enters LINEAR, RANDOM or BASE according to the mode. A restart re-enters the phase that was saved at the last block boundary.

Top module: `test_addr_gen`

## Requirements
- R1: While `rst_n` is low, the generator loads its configuration on each clock edge. After release, `addr` shows the start address in modes 0 (sequential) and 3 (also sequential), and shows the seed 0x00ACE1 in modes 1 (random) and 2 (random-sequential). Any mask overlay is applied to this value.
- R2: In sequential mode, each `req_next` pulse makes the next address the current address plus `cfg_incr`.
- R3: Every address sum is taken modulo 2^25. A value past 0x1FF_FFFF wraps through zero.
- R4: In random mode, each request replaces the address v with {v[23:0], v[24]^v[21]}, starting from the seed. No address is ever zero.
- R5: In random-sequential mode, a base b is followed by b+i*incr for i = 1 to `cfg_run_len`. The next request then shows a new base, which is the shift-register step (rule of R4) of the previous base.
- R6: With `cfg_run_len` equal to 0 in random-sequential mode, every request produces a new base. The output then matches random mode exactly.
- R7: In sequential mode with `cfg_ret_start` set, a `block_done` pulse reloads the start address and returns the sweep counter to 0. With the flag clear, or in any other mode, `block_done` leaves `addr` unchanged.
- R8: A `restart` pulse restores the complete state saved at the most recent `block_done`, or at reset if no boundary has occurred since. The same requests then yield the same addresses. `restart` takes priority over `req_next` and `block_done` in the same cycle.
- R9: `cfg_mask_mode` 1 (fixed) replaces the selected field with the low bits of `cfg_mask_value` and leaves all other bits as the unmasked generator produced them. Modes 0 and 3 leave the address unmasked.
- R10: `cfg_mask_mode` 2 (sweep) replaces the selected field with a counter. The counter starts at 0 after reset, advances by one on each request, and wraps at the field width.
- R11: `cfg_mask_field` selects the field: 0 column [9:0], 1 bank [12:10], 2 bank group [14:13], 3 row [24:15].
- R12: In a cycle with no `req_next`, `block_done` or `restart`, `addr` stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads configuration |
| cfg_mode | input | 2 | 0/3 sequential, 1 random, 2 random-sequential |
| cfg_start | input | 25 | Start address for sequential mode |
| cfg_incr | input | 25 | Step between sequential addresses |
| cfg_run_len | input | 8 | Addresses after each random base |
| cfg_ret_start | input | 1 | Reload start address at each block boundary |
| cfg_mask_mode | input | 2 | 0/3 off, 1 fixed, 2 sweep |
| cfg_mask_field | input | 2 | Field selected for masking |
| cfg_mask_value | input | 10 | Fixed field value |
| req_next | input | 1 | Advance to the following address |
| block_done | input | 1 | Block boundary; saves generator state |
| restart | input | 1 | Restore state saved at the last boundary |
| addr | output | 25 | Current address |

## Verification
Four properties are checked on every cycle. The address holds when no control input pulses. Sequential steps add the increment modulo 2^25. A fixed mask always shows the mask value in the chosen field. A sweep advances its field by one per request. In addition, random-mode addresses are never zero. Only the bench scenarios can show the exact random and random-sequential sequences, the run-length boundary and the zero-run case. The same holds for the block-boundary reload and the faithful replay after restart, since each of these depends on state that builds up over many requests.

// File: rtl/agen_pkg.sv
package agen_pkg;

    typedef enum logic [1:0] {
        MODE_SEQ     = 2'd0,
        MODE_RAND    = 2'd1,
        MODE_RSEQ    = 2'd2,
        MODE_SEQ_ALT = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        MSK_OFF     = 2'd0,
        MSK_FIXED   = 2'd1,
        MSK_SWEEP   = 2'd2,
        MSK_OFF_ALT = 2'd3
    } mask_e;

    typedef enum logic [1:0] {
        PH_LINEAR = 2'd0,
        PH_RANDOM = 2'd1,
        PH_BASE   = 2'd2,
        PH_RUN    = 2'd3
    } phase_e;

endpackage

// File: rtl/agen_walker.sv
module agen_walker
    import agen_pkg::*;
#(
    parameter int                  ADDR_W  = 25,
    parameter int                  RUN_W   = 8,
    parameter int                  FIELD_W = 10,
    parameter logic [ADDR_W-1:0]   SEED    = 25'h000ACE1,
    parameter logic [ADDR_W-1:0]   TAPS    = 25'h1200000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode,
    input  logic [ADDR_W-1:0]   start,
    input  logic [ADDR_W-1:0]   incr,
    input  logic [RUN_W-1:0]    run_len,
    input  logic                ret_start,
    input  logic                sweep_en,
    input  logic [FIELD_W-1:0]  sweep_lim,
    input  logic                next,
    input  logic                block_done,
    input  logic                restart,
    output logic [ADDR_W-1:0]   raw_addr,
    output logic [FIELD_W-1:0]  cyc
);

    // live stepping state
    phase_e              phase;
    logic [ADDR_W-1:0]   cur;
    logic [ADDR_W-1:0]   lfsr;
    logic [RUN_W-1:0]    run_cnt;

    // state saved at the last block boundary
    phase_e              s_phase;
    logic [ADDR_W-1:0]   s_cur;
    logic [ADDR_W-1:0]   s_lfsr;
    logic [RUN_W-1:0]    s_run;
    logic [FIELD_W-1:0]  s_cyc;

    // next-state values
    phase_e              n_phase;
    logic [ADDR_W-1:0]   n_cur;
    logic [ADDR_W-1:0]   n_lfsr;
    logic [RUN_W-1:0]    n_run;
    logic [FIELD_W-1:0]  n_cyc;

    phase_e              init_phase;
    logic [ADDR_W-1:0]   init_cur;

    function automatic logic [ADDR_W-1:0] lfsr_adv(input logic [ADDR_W-1:0] v);
        return {v[ADDR_W-2:0], ^(v & TAPS)};
    endfunction

    always_comb begin
        unique case (mode_e'(mode))
            MODE_RAND: init_phase = PH_RANDOM;
            MODE_RSEQ: init_phase = PH_BASE;
            default:   init_phase = PH_LINEAR;
        endcase
        init_cur = (mode_e'(mode) == MODE_RSEQ) ? SEED : start;
    end

    // transition logic
    always_comb begin
        n_phase = phase;
        n_cur   = cur;
        n_lfsr  = lfsr;
        n_run   = run_cnt;
        n_cyc   = cyc;
        if (next) begin
            if (sweep_en) begin
                n_cyc = (cyc + 1'b1) & sweep_lim;
            end
            unique case (phase)
                PH_LINEAR: n_cur  = cur + incr;
                PH_RANDOM: n_lfsr = lfsr_adv(lfsr);
                PH_BASE, PH_RUN: begin
                    if (run_cnt == run_len) begin
                        n_lfsr  = lfsr_adv(lfsr);
                        n_cur   = lfsr_adv(lfsr);
                        n_run   = '0;
                        n_phase = PH_BASE;
                    end else begin
                        n_cur   = cur + incr;
                        n_run   = run_cnt + 1'b1;
                        n_phase = PH_RUN;
                    end
                end
            endcase
        end
        if (block_done && ret_start && phase == PH_LINEAR) begin
            n_cur = start;
            n_cyc = '0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= init_phase;
            cur     <= init_cur;
            lfsr    <= SEED;
            run_cnt <= '0;
            cyc     <= '0;
            s_phase <= init_phase;
            s_cur   <= init_cur;
            s_lfsr  <= SEED;
            s_run   <= '0;
            s_cyc   <= '0;
        end else if (restart) begin
            phase   <= s_phase;
            cur     <= s_cur;
            lfsr    <= s_lfsr;
            run_cnt <= s_run;
            cyc     <= s_cyc;
        end else begin
            phase   <= n_phase;
            cur     <= n_cur;
            lfsr    <= n_lfsr;
            run_cnt <= n_run;
            cyc     <= n_cyc;
            if (block_done) begin
                s_phase <= n_phase;
                s_cur   <= n_cur;
                s_lfsr  <= n_lfsr;
                s_run   <= n_run;
                s_cyc   <= n_cyc;
            end
        end
    end

    // output selection
    always_comb begin
        unique case (phase)
            PH_RANDOM: raw_addr = lfsr;
            default:   raw_addr = cur;
        endcase
    end

endmodule

// File: rtl/agen_field_mask.sv
module agen_field_mask
    import agen_pkg::*;
#(
    parameter int ADDR_W  = 25,
    parameter int COL_W   = 10,
    parameter int BANK_W  = 3,
    parameter int BGRP_W  = 2,
    parameter int ROW_W   = 10,
    parameter int FIELD_W = 10
) (
    input  logic [ADDR_W-1:0]   raw,
    input  logic [1:0]          mask_mode,
    input  logic [1:0]          field,
    input  logic [FIELD_W-1:0]  fval,
    input  logic [FIELD_W-1:0]  cyc,
    output logic [ADDR_W-1:0]   addr,
    output logic [FIELD_W-1:0]  lim
);

    localparam int NFLD = 4;
    localparam int FW [NFLD] = '{COL_W, BANK_W, BGRP_W, ROW_W};
    localparam int FL [NFLD] = '{0, COL_W, COL_W + BANK_W, COL_W + BANK_W + BGRP_W};
    localparam logic [ADDR_W-1:0] ALL1 = {ADDR_W{1'b1}};

    logic [FIELD_W-1:0] val;
    logic [ADDR_W-1:0]  fmsk  [NFLD];
    logic [ADDR_W-1:0]  place [NFLD];
    logic [FIELD_W-1:0] lims  [NFLD];

    assign val = (mask_e'(mask_mode) == MSK_FIXED) ? fval : cyc;

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        logic [ADDR_W-1:0] ones_low;
        assign ones_low = ALL1 >> (ADDR_W - FW[g]);
        assign fmsk[g]  = ones_low << FL[g];
        assign lims[g]  = ones_low[FIELD_W-1:0];
        assign place[g] = (ADDR_W'(val) << FL[g]) & fmsk[g];
    end

    always_comb begin
        lim = lims[field];
        unique case (mask_e'(mask_mode))
            MSK_FIXED, MSK_SWEEP: addr = (raw & ~fmsk[field]) | place[field];
            default:              addr = raw;
        endcase
    end

endmodule

// File: rtl/test_addr_gen.sv
module test_addr_gen
    import agen_pkg::*;
#(
    parameter int                ADDR_W  = 25,
    parameter int                RUN_W   = 8,
    parameter int                COL_W   = 10,
    parameter int                BANK_W  = 3,
    parameter int                BGRP_W  = 2,
    parameter int                ROW_W   = 10,
    parameter int                FIELD_W = 10,
    parameter logic [ADDR_W-1:0] SEED    = 25'h000ACE1,
    parameter logic [ADDR_W-1:0] TAPS    = 25'h1200000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_mode,
    input  logic [ADDR_W-1:0]   cfg_start,
    input  logic [ADDR_W-1:0]   cfg_incr,
    input  logic [RUN_W-1:0]    cfg_run_len,
    input  logic                cfg_ret_start,
    input  logic [1:0]          cfg_mask_mode,
    input  logic [1:0]          cfg_mask_field,
    input  logic [FIELD_W-1:0]  cfg_mask_value,
    input  logic                req_next,
    input  logic                block_done,
    input  logic                restart,
    output logic [ADDR_W-1:0]   addr
);

    logic [ADDR_W-1:0]  raw_addr;
    logic [FIELD_W-1:0] cyc;
    logic [FIELD_W-1:0] lim;
    logic               sweep_en;

    assign sweep_en = (mask_e'(cfg_mask_mode) == MSK_SWEEP);

    agen_walker #(
        .ADDR_W (ADDR_W),
        .RUN_W  (RUN_W),
        .FIELD_W(FIELD_W),
        .SEED   (SEED),
        .TAPS   (TAPS)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (cfg_mode),
        .start     (cfg_start),
        .incr      (cfg_incr),
        .run_len   (cfg_run_len),
        .ret_start (cfg_ret_start),
        .sweep_en  (sweep_en),
        .sweep_lim (lim),
        .next      (req_next),
        .block_done(block_done),
        .restart   (restart),
        .raw_addr  (raw_addr),
        .cyc       (cyc)
    );

    agen_field_mask #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W),
        .BANK_W (BANK_W),
        .BGRP_W (BGRP_W),
        .ROW_W  (ROW_W),
        .FIELD_W(FIELD_W)
    ) u_mask (
        .raw      (raw_addr),
        .mask_mode(cfg_mask_mode),
        .field    (cfg_mask_field),
        .fval     (cfg_mask_value),
        .cyc      (cyc),
        .addr     (addr),
        .lim      (lim)
    );

endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
    parameter int ADDR_W  = 25,
    parameter int COL_W   = 10,
    parameter int BANK_W  = 3,
    parameter int BGRP_W  = 2,
    parameter int FIELD_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          cfg_mode,
    input logic [ADDR_W-1:0]   cfg_incr,
    input logic [1:0]          cfg_mask_mode,
    input logic [1:0]          cfg_mask_field,
    input logic [FIELD_W-1:0]  cfg_mask_value,
    input logic                req_next,
    input logic                block_done,
    input logic                restart,
    input logic [ADDR_W-1:0]   addr
);

    localparam logic [ADDR_W-1:0] ALL1 = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] fm;
    logic [ADDR_W-1:0] lim;
    logic [ADDR_W-1:0] fv_now;
    logic [ADDR_W-1:0] fv_cfg;
    int                lo;

    always_comb begin
        unique case (cfg_mask_field)
            2'd0:    begin lo = 0;                        lim = ALL1 >> (ADDR_W - COL_W);  end
            2'd1:    begin lo = COL_W;                    lim = ALL1 >> (ADDR_W - BANK_W); end
            2'd2:    begin lo = COL_W + BANK_W;           lim = ALL1 >> (ADDR_W - BGRP_W); end
            default: begin lo = COL_W + BANK_W + BGRP_W;  lim = ALL1 >> (COL_W + BANK_W + BGRP_W); end
        endcase
        fm     = lim << lo;
        fv_now = (addr & fm) >> lo;
        fv_cfg = ADDR_W'(cfg_mask_value) & lim;
    end

    // R12: no control pulse, no address change
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_next && !block_done && !restart) |=> $stable(addr));

    // R2, R3: sequential step adds the increment modulo 2^25
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0 && cfg_mask_mode == 2'd0 && req_next && !block_done && !restart)
        |=> addr == $past(addr) + $past(cfg_incr));

    // R4: random addresses are never zero
    p_rand_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1 && cfg_mask_mode == 2'd0) |-> addr != '0);

    // R9: fixed mask pins the chosen field
    p_fixed_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mask_mode == 2'd1) |-> fv_now == fv_cfg);

    // R10: sweep field advances by one per request
    p_sweep_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mask_mode == 2'd2 && req_next && !block_done && !restart)
        |=> fv_now == (($past(fv_now) + ADDR_W'(1)) & lim));

endmodule

bind test_addr_gen agen_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode      (cfg_mode),
    .cfg_incr      (cfg_incr),
    .cfg_mask_mode (cfg_mask_mode),
    .cfg_mask_field(cfg_mask_field),
    .cfg_mask_value(cfg_mask_value),
    .req_next      (req_next),
    .block_done    (block_done),
    .restart       (restart),
    .addr          (addr)
);

// File: tb/test_addr_gen_test.sv
module test_addr_gen_test;

    localparam int          CLK_P = 10;
    localparam logic [24:0] SEED  = 25'h000ACE1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [24:0] cfg_start = '0;
    logic [24:0] cfg_incr = '0;
    logic [7:0]  cfg_run_len = '0;
    logic        cfg_ret_start = 1'b0;
    logic [1:0]  cfg_mask_mode = 2'd0;
    logic [1:0]  cfg_mask_field = 2'd0;
    logic [9:0]  cfg_mask_value = '0;
    logic        req_next = 1'b0;
    logic        block_done = 1'b0;
    logic        restart = 1'b0;
    logic [24:0] addr;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    test_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_start(cfg_start),
        .cfg_incr(cfg_incr), .cfg_run_len(cfg_run_len), .cfg_ret_start(cfg_ret_start),
        .cfg_mask_mode(cfg_mask_mode), .cfg_mask_field(cfg_mask_field),
        .cfg_mask_value(cfg_mask_value), .req_next(req_next), .block_done(block_done),
        .restart(restart), .addr(addr)
    );

    function automatic logic [24:0] adv(input logic [24:0] v);
        return {v[23:0], v[24] ^ v[21]};
    endfunction

    // field overlay per R9/R10/R11
    function automatic logic [24:0] overlay(input logic [24:0] raw, input logic [1:0] fld,
                                            input int val);
        int lo, w;
        logic [24:0] fm;
        case (fld)
            2'd0: begin lo = 0;  w = 10; end
            2'd1: begin lo = 10; w = 3;  end
            2'd2: begin lo = 13; w = 2;  end
            default: begin lo = 15; w = 10; end
        endcase
        fm = ((25'd1 << w) - 25'd1) << lo;
        return (raw & ~fm) | ((25'(val) << lo) & fm);
    endfunction

    task automatic chk(input logic [24:0] exp, input string tag);
        n_chk++;
        if (addr !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, addr, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m, input logic [24:0] st, input logic [24:0] inc,
                            input logic [7:0] rl, input logic rs, input logic [1:0] mm,
                            input logic [1:0] fld, input logic [9:0] fv);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_mode = m; cfg_start = st; cfg_incr = inc; cfg_run_len = rl;
        cfg_ret_start = rs; cfg_mask_mode = mm; cfg_mask_field = fld; cfg_mask_value = fv;
        req_next = 1'b0; block_done = 1'b0; restart = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input logic n, input logic d, input logic r);
        req_next = n; block_done = d; restart = r;
        @(negedge clk);
        req_next = 1'b0; block_done = 1'b0; restart = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [24:0] e;
        logic [24:0] b;
        logic [24:0] e3;
        logic [24:0] rec [8];
        int cnt;

        // R1 reset state
        do_reset(2'd0, 25'h0123456, 25'd4, 8'd0, 1'b0, 2'd0, 2'd0, '0);
        chk(25'h0123456, "R1 seq reset");
        do_reset(2'd3, 25'h0001000, 25'd4, 8'd0, 1'b0, 2'd0, 2'd0, '0);
        chk(25'h0001000, "R1 mode3 reset");
        do_reset(2'd1, 25'h0001000, 25'd4, 8'd0, 1'b0, 2'd0, 2'd0, '0);
        chk(SEED, "R1 rand reset");

        // R2 sequential sweeps over several increments
        for (int ii = 0; ii < 5; ii++) begin
            logic [24:0] inc;
            inc = (ii == 4) ? 25'h1FFFFFF : 25'(ii * 5 + 1);
            do_reset(2'd0, 25'h1FFFFF0, inc, 8'd0, 1'b0, 2'd0, 2'd0, '0);
            for (int k = 1; k <= 12; k++) begin
                pulse(1'b1, 1'b0, 1'b0);
                chk(25'h1FFFFF0 + 25'(k) * inc, "R2 seq step");
            end
        end

        // R3 wrap through zero
        do_reset(2'd0, 25'h1FFFFFE, 25'd3, 8'd0, 1'b0, 2'd0, 2'd0, '0);
        pulse(1'b1, 1'b0, 1'b0);
        chk(25'h0000001, "R3 wrap");

        // R4 random sequence
        do_reset(2'd1, 25'h0, 25'd1, 8'd0, 1'b0, 2'd0, 2'd0, '0);
        e = SEED;
        for (int k = 0; k < 40; k++) begin
            chk(e, "R4 random");
            pulse(1'b1, 1'b0, 1'b0);
            e = adv(e);
        end

        // R5 / R6 random-sequential runs
        for (int rl = 0; rl < 4; rl++) begin
            do_reset(2'd2, 25'h0, 25'd5, 8'(rl), 1'b0, 2'd0, 2'd0, '0);
            b = SEED;
            cnt = 0;
            for (int k = 0; k < 30; k++) begin
                if (rl == 0) chk(b, "R6 zero run");
                else         chk(b + 25'(cnt * 5), "R5 base plus run");
                pulse(1'b1, 1'b0, 1'b0);
                if (cnt == rl) begin b = adv(b); cnt = 0; end
                else cnt++;
            end
        end

        // R7 return to start
        do_reset(2'd0, 25'h0001000, 25'd4, 8'd0, 1'b1, 2'd0, 2'd0, '0);
        repeat (5) pulse(1'b1, 1'b0, 1'b0);
        chk(25'h0001014, "R7 before boundary");
        pulse(1'b0, 1'b1, 1'b0);
        chk(25'h0001000, "R7 reload start");
        do_reset(2'd0, 25'h0001000, 25'd4, 8'd0, 1'b0, 2'd0, 2'd0, '0);
        repeat (5) pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b0, 1'b1, 1'b0);
        chk(25'h0001014, "R7 no reload");
        pulse(1'b1, 1'b0, 1'b0);
        chk(25'h0001018, "R7 continue");

        // R8 restart replay, random mode, flag set but ignored there (R7)
        do_reset(2'd1, 25'h0, 25'd1, 8'd0, 1'b1, 2'd0, 2'd0, '0);
        repeat (3) pulse(1'b1, 1'b0, 1'b0);
        e3 = adv(adv(adv(SEED)));
        pulse(1'b0, 1'b1, 1'b0);
        chk(e3, "R7 random boundary unchanged");
        repeat (5) pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b1, 1'b0, 1'b1);
        chk(e3, "R8 restart restores");
        e = e3;
        for (int k = 0; k < 5; k++) begin
            pulse(1'b1, 1'b0, 1'b0);
            e = adv(e);
            chk(e, "R8 replay random");
        end

        // R8 random-sequential replay from reset snapshot
        do_reset(2'd2, 25'h0, 25'd7, 8'd2, 1'b0, 2'd0, 2'd0, '0);
        for (int k = 0; k < 8; k++) begin
            rec[k] = addr;
            pulse(1'b1, 1'b0, 1'b0);
        end
        pulse(1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++) begin
            chk(rec[k], "R8 replay rseq");
            pulse(1'b1, 1'b0, 1'b0);
        end

        // R9 / R11 fixed mask on every field
        for (int f = 0; f < 4; f++) begin
            do_reset(2'd0, 25'h0ABCDEF, 25'h0000123, 8'd0, 1'b0, 2'd1, 2'(f), 10'h2A5);
            for (int k = 0; k < 4; k++) begin
                chk(overlay(25'h0ABCDEF + 25'(k) * 25'h123, 2'(f), 10'h2A5), "R9 R11 fixed field");
                pulse(1'b1, 1'b0, 1'b0);
            end
        end
        do_reset(2'd0, 25'h0ABCDEF, 25'd1, 8'd0, 1'b0, 2'd3, 2'd1, 10'h2A5);
        chk(25'h0ABCDEF, "R9 mode3 unmasked");

        // R10 sweep on bank field over sequential raw
        do_reset(2'd0, 25'h0, 25'd1, 8'd0, 1'b0, 2'd2, 2'd1, '0);
        for (int k = 0; k < 20; k++) begin
            chk(overlay(25'(k), 2'd1, k % 8), "R10 sweep bank");
            pulse(1'b1, 1'b0, 1'b0);
        end
        // R10 sweep on bank group over random raw
        do_reset(2'd1, 25'h0, 25'd1, 8'd0, 1'b0, 2'd2, 2'd2, '0);
        e = SEED;
        for (int k = 0; k < 10; k++) begin
            chk(overlay(e, 2'd2, k % 4), "R10 sweep bank group");
            pulse(1'b1, 1'b0, 1'b0);
            e = adv(e);
        end

        // R12 hold without requests
        e = addr;
        for (int k = 0; k < 4; k++) begin
            pulse(1'b0, 1'b0, 1'b0);
            chk(e, "R12 hold");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule